// File: doc/BRIEF.md
# Per-Thread Squash Request Arbiter

This block sits between the execute stage and the commit stage of a multi-threaded out-of-order core. In any cycle, several sources may ask for a pipeline flush: branch resolution ports that found a mispredicted branch, and memory-ordering ports that found a load which ran ahead of an older store to the same address. Each request names a hardware thread, a sequence number, a PC and its kind. For every thread, the block selects one winner among that cycle's requests. It then presents a registered squash command to commit for exactly one cycle.

The winner is always the oldest request, meaning the smallest sequence number. The two kinds differ in how much they flush. A branch keeps itself, is recorded as the mispredicting instruction, and redirects fetch to its corrected target. A memory-ordering violation flushes the offending load itself together with everything younger, and refetches from that load's own PC. When a branch and a violation carry the same sequence number, the violation wins, because the larger flush is the only safe choice. No arbitration state survives from one cycle to the next.

Top module: `squash_arbiter`

## Requirements
- R1: A thread with at least one valid request at clock edge N shows `sq_valid`=1 after edge N. A thread with no request at edge N shows `sq_valid`=0 after it, so each win lasts exactly one cycle.
- R2: The winning request of a thread has the smallest sequence number among that thread's valid requests in the cycle. Sequence numbers are unsigned, and a smaller value means an older instruction.
- R3: When a branch request and a violation request of one thread share the smallest sequence number, the violation wins.
- R4: Among branch requests that tie on the smallest sequence number (with no violation at that number), the lowest-indexed branch port wins. Among tied violations, the highest-indexed violation port wins.
- R5: A winning violation gives `sq_incl_self`=1, `sq_pc` equal to the violating load's own PC, `sq_mis_valid`=0 and `sq_mis_tag`=0.
- R6: A winning branch gives `sq_incl_self`=0, `sq_pc` equal to its corrected target, `sq_mis_valid`=1 and `sq_mis_tag` equal to its sequence number.
- R7: Requests for one thread never change another thread's outputs. A request's thread is given by its thread-ID field.
- R8: Arbitration holds no memory across cycles. A younger request wins in its own cycle even when an older request won in the cycle before.
- R9: While `sq_valid` of a thread is 0, that thread's `sq_seq`, `sq_pc`, `sq_incl_self`, `sq_mis_valid` and `sq_mis_tag` are all 0.
- R10: A clock edge with `rst_n`=0 clears every output to 0, whatever requests are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | NB | One valid bit per branch-mispredict port |
| br_tid | input | NB*TID_W | Thread ID of each branch port |
| br_seq | input | NB*SEQ_W | Sequence number of each mispredicted branch |
| br_target | input | NB*PC_W | Corrected target PC of each branch |
| mv_valid | input | NM | One valid bit per memory-order violation port |
| mv_tid | input | NM*TID_W | Thread ID of each violation port |
| mv_seq | input | NM*SEQ_W | Sequence number of each violating load |
| mv_pc | input | NM*PC_W | PC of each violating load |
| sq_valid | output | NT | Squash command valid, one bit per thread |
| sq_seq | output | NT*SEQ_W | Winning sequence number per thread |
| sq_pc | output | NT*PC_W | Redirect PC per thread |
| sq_incl_self | output | NT | Squash includes the winning instruction itself |
| sq_mis_valid | output | NT | Mispredicting-instruction tag is valid |
| sq_mis_tag | output | NT*SEQ_W | Sequence number of the mispredicting branch |

## Verification
Sequence numbers are drawn from a range of eight values, so ties between branches, between violations, and across the two kinds happen often. A design that used a strict compare for violations would let an equal-numbered branch keep the slot and leave the faulting load in flight. A design with the tie-break reversed would report the wrong port's PC. Directed cases cover a violation that arrives in the cycle after a branch won, which catches any carried-over state, and a request for one thread with the other threads idle, which catches bleed between threads and fields left non-zero while no squash is pending. Requests are also held during reset, to show that reset dominates them.

// File: rtl/squash_arb_pkg.sv
// Package: shared types and the slot-claim rule for the squash arbiter.
// Assumes sequence numbers are at most 64 bits wide and do not wrap.
package squash_arb_pkg;

    typedef enum logic {
        SQ_BRANCH = 1'b0,
        SQ_MEMORD = 1'b1
    } sq_kind_e;

    // Decide whether a candidate request takes a thread's squash slot.
    // A branch needs a strictly older number; a violation also wins ties.
    function automatic logic claims_slot(
        input sq_kind_e    kind,
        input logic        busy,
        input logic [63:0] cand_seq,
        input logic [63:0] held_seq
    );
        if (!busy)
            return 1'b1;
        if (kind == SQ_MEMORD)
            return cand_seq <= held_seq;
        return cand_seq < held_seq;
    endfunction

endpackage

// File: rtl/squash_req_route.sv
// Module: decodes one request port into a per-thread hit vector.
// Assumes a request whose thread ID is out of range is dropped.
module squash_req_route #(
    parameter int NT    = 4,
    parameter int TID_W = 2
) (
    input  logic             req_valid,
    input  logic [TID_W-1:0] req_tid,
    output logic [NT-1:0]    thread_hit
);

    for (genvar t = 0; t < NT; t++) begin : g_hit
        // Flag this thread when the port is valid and names it.
        assign thread_hit[t] = req_valid && (req_tid == TID_W'(t));
    end

    // R7: a request reaches at most one thread.
    always_comb begin
        a_r7_single_thread: assert ($onehot0(thread_hit));
    end

endmodule

// File: rtl/squash_thread_arb.sv
// Module: combinational winner selection for a single thread.
// Requests are walked in a fixed order, all branch ports first and then all
// violation ports, each in ascending index. Nothing is kept between cycles.
// The clock and reset are used only by the assertions.
module squash_thread_arb
    import squash_arb_pkg::*;
#(
    parameter int NB    = 2,
    parameter int NM    = 2,
    parameter int SEQ_W = 32,
    parameter int PC_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NB-1:0]       br_hit,
    input  logic [NB*SEQ_W-1:0] br_seq,
    input  logic [NB*PC_W-1:0]  br_target,
    input  logic [NM-1:0]       mv_hit,
    input  logic [NM*SEQ_W-1:0] mv_seq,
    input  logic [NM*PC_W-1:0]  mv_pc,
    output logic                win_valid,
    output logic [SEQ_W-1:0]    win_seq,
    output logic [PC_W-1:0]     win_pc,
    output logic                win_incl,
    output logic                win_mis_valid,
    output logic [SEQ_W-1:0]    win_mis_tag
);

    sq_kind_e win_kind;

    // Walk the requests in order and keep whichever claims the slot last.
    always_comb begin
        win_valid = 1'b0;
        win_seq   = '0;
        win_pc    = '0;
        win_kind  = SQ_BRANCH;
        for (int i = 0; i < NB; i++) begin
            if (br_hit[i] && claims_slot(SQ_BRANCH, win_valid,
                    64'(br_seq[i*SEQ_W +: SEQ_W]), 64'(win_seq))) begin
                win_valid = 1'b1;
                win_seq   = br_seq[i*SEQ_W +: SEQ_W];
                win_pc    = br_target[i*PC_W +: PC_W];
                win_kind  = SQ_BRANCH;
            end
        end
        for (int j = 0; j < NM; j++) begin
            if (mv_hit[j] && claims_slot(SQ_MEMORD, win_valid,
                    64'(mv_seq[j*SEQ_W +: SEQ_W]), 64'(win_seq))) begin
                win_valid = 1'b1;
                win_seq   = mv_seq[j*SEQ_W +: SEQ_W];
                win_pc    = mv_pc[j*PC_W +: PC_W];
                win_kind  = SQ_MEMORD;
            end
        end
    end

    // Derive the squash shape from the kind of the winner.
    always_comb begin
        win_incl      = win_valid && (win_kind == SQ_MEMORD);
        win_mis_valid = win_valid && (win_kind == SQ_BRANCH);
        win_mis_tag   = win_mis_valid ? win_seq : '0;
    end

    // R1: any request for this thread yields a winner, none yields none.
    a_r1_request_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|{br_hit, mv_hit}) == win_valid);

    for (genvar i = 0; i < NB; i++) begin : g_br_chk
        // R2: no branch request is older than the winner.
        a_r2_branch_not_older: assert property (@(posedge clk) disable iff (!rst_n)
            br_hit[i] |-> (win_seq <= br_seq[i*SEQ_W +: SEQ_W]));
    end

    for (genvar j = 0; j < NM; j++) begin : g_mv_chk
        // R2: no violation request is older than the winner.
        a_r2_violation_not_older: assert property (@(posedge clk) disable iff (!rst_n)
            mv_hit[j] |-> (win_seq <= mv_seq[j*SEQ_W +: SEQ_W]));
        // R3: a violation at the winning number forces include-self.
        a_r3_tie_goes_to_violation: assert property (@(posedge clk) disable iff (!rst_n)
            (mv_hit[j] && (win_seq == mv_seq[j*SEQ_W +: SEQ_W])) |-> win_incl);
    end

endmodule

// File: rtl/squash_out_reg.sv
// Module: registers one thread's squash command toward commit.
// Fields are forced to zero whenever no squash is issued.
module squash_out_reg #(
    parameter int SEQ_W = 32,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid,
    input  logic [SEQ_W-1:0] win_seq,
    input  logic [PC_W-1:0]  win_pc,
    input  logic             win_incl,
    input  logic             win_mis_valid,
    input  logic [SEQ_W-1:0] win_mis_tag,
    output logic             sq_valid,
    output logic [SEQ_W-1:0] sq_seq,
    output logic [PC_W-1:0]  sq_pc,
    output logic             sq_incl_self,
    output logic             sq_mis_valid,
    output logic [SEQ_W-1:0] sq_mis_tag
);

    // Capture this cycle's winner, or zeros, for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !win_valid) begin
            sq_valid     <= 1'b0;
            sq_seq       <= '0;
            sq_pc        <= '0;
            sq_incl_self <= 1'b0;
            sq_mis_valid <= 1'b0;
            sq_mis_tag   <= '0;
        end else begin
            sq_valid     <= 1'b1;
            sq_seq       <= win_seq;
            sq_pc        <= win_pc;
            sq_incl_self <= win_incl;
            sq_mis_valid <= win_mis_valid;
            sq_mis_tag   <= win_mis_tag;
        end
    end

    // R10: a reset edge leaves no squash pending.
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !sq_valid);

    // R9: idle thread shows all-zero fields.
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_valid |-> (sq_seq == '0 && sq_pc == '0 && !sq_incl_self
                       && !sq_mis_valid && sq_mis_tag == '0));

    // R5: include-self squash never names a mispredicting branch.
    a_r5_violation_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && sq_incl_self) |-> (!sq_mis_valid && sq_mis_tag == '0));

    // R6: branch squash records itself as the mispredicting instruction.
    a_r6_branch_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !sq_incl_self) |-> (sq_mis_valid && sq_mis_tag == sq_seq));

endmodule

// File: rtl/squash_arbiter.sv
// Module: top of the per-thread squash arbiter.
// Routes every branch and violation port to its thread, runs one arbiter per
// thread and registers each thread's command. Assumes sequence numbers do not
// wrap and that SEQ_W is at most 64.
module squash_arbiter
    import squash_arb_pkg::*;
#(
    parameter int NT    = 4,
    parameter int NB    = 2,
    parameter int NM    = 2,
    parameter int SEQ_W = 32,
    parameter int PC_W  = 32,
    localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NB-1:0]       br_valid,
    input  logic [NB*TID_W-1:0] br_tid,
    input  logic [NB*SEQ_W-1:0] br_seq,
    input  logic [NB*PC_W-1:0]  br_target,
    input  logic [NM-1:0]       mv_valid,
    input  logic [NM*TID_W-1:0] mv_tid,
    input  logic [NM*SEQ_W-1:0] mv_seq,
    input  logic [NM*PC_W-1:0]  mv_pc,
    output logic [NT-1:0]       sq_valid,
    output logic [NT*SEQ_W-1:0] sq_seq,
    output logic [NT*PC_W-1:0]  sq_pc,
    output logic [NT-1:0]       sq_incl_self,
    output logic [NT-1:0]       sq_mis_valid,
    output logic [NT*SEQ_W-1:0] sq_mis_tag
);

    logic [NT-1:0] br_mask [NB];
    logic [NT-1:0] mv_mask [NM];

    for (genvar i = 0; i < NB; i++) begin : g_br_route
        squash_req_route #(.NT(NT), .TID_W(TID_W)) u_route (
            .req_valid  (br_valid[i]),
            .req_tid    (br_tid[i*TID_W +: TID_W]),
            .thread_hit (br_mask[i])
        );
    end

    for (genvar j = 0; j < NM; j++) begin : g_mv_route
        squash_req_route #(.NT(NT), .TID_W(TID_W)) u_route (
            .req_valid  (mv_valid[j]),
            .req_tid    (mv_tid[j*TID_W +: TID_W]),
            .thread_hit (mv_mask[j])
        );
    end

    for (genvar t = 0; t < NT; t++) begin : g_thread
        logic [NB-1:0]    th_br_hit;
        logic [NM-1:0]    th_mv_hit;
        logic             w_valid;
        logic [SEQ_W-1:0] w_seq;
        logic [PC_W-1:0]  w_pc;
        logic             w_incl;
        logic             w_mis_valid;
        logic [SEQ_W-1:0] w_mis_tag;

        // Gather the ports that target this thread.
        always_comb begin
            for (int i = 0; i < NB; i++) th_br_hit[i] = br_mask[i][t];
            for (int j = 0; j < NM; j++) th_mv_hit[j] = mv_mask[j][t];
        end

        squash_thread_arb #(
            .NB(NB), .NM(NM), .SEQ_W(SEQ_W), .PC_W(PC_W)
        ) u_arb (
            .clk           (clk),
            .rst_n         (rst_n),
            .br_hit        (th_br_hit),
            .br_seq        (br_seq),
            .br_target     (br_target),
            .mv_hit        (th_mv_hit),
            .mv_seq        (mv_seq),
            .mv_pc         (mv_pc),
            .win_valid     (w_valid),
            .win_seq       (w_seq),
            .win_pc        (w_pc),
            .win_incl      (w_incl),
            .win_mis_valid (w_mis_valid),
            .win_mis_tag   (w_mis_tag)
        );

        squash_out_reg #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_out (
            .clk           (clk),
            .rst_n         (rst_n),
            .win_valid     (w_valid),
            .win_seq       (w_seq),
            .win_pc        (w_pc),
            .win_incl      (w_incl),
            .win_mis_valid (w_mis_valid),
            .win_mis_tag   (w_mis_tag),
            .sq_valid      (sq_valid[t]),
            .sq_seq        (sq_seq[t*SEQ_W +: SEQ_W]),
            .sq_pc         (sq_pc[t*PC_W +: PC_W]),
            .sq_incl_self  (sq_incl_self[t]),
            .sq_mis_valid  (sq_mis_valid[t]),
            .sq_mis_tag    (sq_mis_tag[t*SEQ_W +: SEQ_W])
        );
    end

endmodule

// File: tb/tb_squash_arbiter.sv
`timescale 1ns/1ps
module tb_squash_arbiter;

    localparam int NT = 4, NB = 2, NM = 2, SEQ_W = 32, PC_W = 32, TID_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NB-1:0]       br_valid;
    logic [NB*TID_W-1:0] br_tid;
    logic [NB*SEQ_W-1:0] br_seq;
    logic [NB*PC_W-1:0]  br_target;
    logic [NM-1:0]       mv_valid;
    logic [NM*TID_W-1:0] mv_tid;
    logic [NM*SEQ_W-1:0] mv_seq;
    logic [NM*PC_W-1:0]  mv_pc;
    logic [NT-1:0]       sq_valid, sq_incl_self, sq_mis_valid;
    logic [NT*SEQ_W-1:0] sq_seq, sq_mis_tag;
    logic [NT*PC_W-1:0]  sq_pc;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] e_seq [NT];
    logic [31:0] e_pc  [NT];
    logic [31:0] e_tag [NT];
    logic        e_v   [NT];
    logic        e_inc [NT];
    logic        e_mv  [NT];

    always #10 clk = ~clk;

    squash_arbiter #(.NT(NT), .NB(NB), .NM(NM), .SEQ_W(SEQ_W), .PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_tid(br_tid), .br_seq(br_seq), .br_target(br_target),
        .mv_valid(mv_valid), .mv_tid(mv_tid), .mv_seq(mv_seq), .mv_pc(mv_pc),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_pc(sq_pc),
        .sq_incl_self(sq_incl_self), .sq_mis_valid(sq_mis_valid), .sq_mis_tag(sq_mis_tag)
    );

    task automatic clear_reqs();
        br_valid = '0; br_tid = '0; br_seq = '0; br_target = '0;
        mv_valid = '0; mv_tid = '0; mv_seq = '0; mv_pc = '0;
    endtask

    task automatic put_br(int p, int tid, int seq, int pc);
        br_valid[p] = 1'b1;
        br_tid[p*TID_W +: TID_W] = TID_W'(tid);
        br_seq[p*SEQ_W +: SEQ_W] = 32'(seq);
        br_target[p*PC_W +: PC_W] = 32'(pc);
    endtask

    task automatic put_mv(int p, int tid, int seq, int pc);
        mv_valid[p] = 1'b1;
        mv_tid[p*TID_W +: TID_W] = TID_W'(tid);
        mv_seq[p*SEQ_W +: SEQ_W] = 32'(seq);
        mv_pc[p*PC_W +: PC_W] = 32'(pc);
    endtask

    // Reference: find the oldest number; a violation at it wins (highest port),
    // otherwise the lowest branch port at it wins.
    task automatic compute_expected();
        for (int t = 0; t < NT; t++) begin
            logic found = 1'b0;
            logic [31:0] mn = '0;
            e_v[t] = 0; e_seq[t] = 0; e_pc[t] = 0; e_tag[t] = 0; e_inc[t] = 0; e_mv[t] = 0;
            if (!rst_n) continue;
            for (int i = 0; i < NB; i++)
                if (br_valid[i] && br_tid[i*TID_W +: TID_W] == TID_W'(t) &&
                    (!found || br_seq[i*SEQ_W +: SEQ_W] < mn)) begin
                    found = 1; mn = br_seq[i*SEQ_W +: SEQ_W];
                end
            for (int j = 0; j < NM; j++)
                if (mv_valid[j] && mv_tid[j*TID_W +: TID_W] == TID_W'(t) &&
                    (!found || mv_seq[j*SEQ_W +: SEQ_W] < mn)) begin
                    found = 1; mn = mv_seq[j*SEQ_W +: SEQ_W];
                end
            if (!found) continue;
            e_v[t] = 1; e_seq[t] = mn;
            for (int j = 0; j < NM; j++)
                if (mv_valid[j] && mv_tid[j*TID_W +: TID_W] == TID_W'(t) &&
                    mv_seq[j*SEQ_W +: SEQ_W] == mn) begin
                    e_inc[t] = 1; e_pc[t] = mv_pc[j*PC_W +: PC_W];
                end
            if (!e_inc[t]) begin
                for (int i = NB - 1; i >= 0; i--)
                    if (br_valid[i] && br_tid[i*TID_W +: TID_W] == TID_W'(t) &&
                        br_seq[i*SEQ_W +: SEQ_W] == mn)
                        e_pc[t] = br_target[i*PC_W +: PC_W];
                e_mv[t] = 1; e_tag[t] = mn;
            end
        end
    endtask

    task automatic check_all(string tag);
        for (int t = 0; t < NT; t++) begin
            n_checks++;
            if (sq_valid[t] !== e_v[t] || sq_seq[t*SEQ_W +: SEQ_W] !== e_seq[t] ||
                sq_pc[t*PC_W +: PC_W] !== e_pc[t] || sq_incl_self[t] !== e_inc[t] ||
                sq_mis_valid[t] !== e_mv[t] || sq_mis_tag[t*SEQ_W +: SEQ_W] !== e_tag[t]) begin
                n_fail++;
                $display("FAIL %s thread %0d: act v=%0b seq=%0d pc=%h inc=%0b mv=%0b tag=%0d exp v=%0b seq=%0d pc=%h inc=%0b mv=%0b tag=%0d",
                    tag, t, sq_valid[t], sq_seq[t*SEQ_W +: SEQ_W], sq_pc[t*PC_W +: PC_W],
                    sq_incl_self[t], sq_mis_valid[t], sq_mis_tag[t*SEQ_W +: SEQ_W],
                    e_v[t], e_seq[t], e_pc[t], e_inc[t], e_mv[t], e_tag[t]);
            end
        end
    endtask

    // Inputs are set at a falling edge; results are read at the next falling edge.
    task automatic step(string tag);
        compute_expected();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);
        clear_reqs();
        @(negedge clk);
        // R10: requests present while reset is held are discarded.
        put_br(0, 1, 3, 32'h100); put_mv(1, 2, 4, 32'h200);
        step("R10 reset");
        step("R10 reset hold");
        rst_n = 1'b1;
        clear_reqs();
        step("R1 idle");

        // R6: single branch.
        put_br(1, 0, 20, 32'hA000);
        step("R6 branch");
        // R1: pulse ends when requests stop; R9 fields return to zero.
        clear_reqs();
        step("R1 R9 pulse end");

        // R5: single violation.
        put_mv(0, 3, 11, 32'hB000);
        step("R5 violation");

        // R3: tie between branch and violation on one thread.
        clear_reqs();
        put_br(0, 2, 7, 32'hC000); put_mv(0, 2, 7, 32'hC100);
        step("R3 tie");

        // R2: older branch beats younger violation.
        clear_reqs();
        put_br(1, 1, 5, 32'hD000); put_mv(1, 1, 6, 32'hD100);
        step("R2 older branch");

        // R4: branch ties resolve to port 0, violation ties to port 1.
        clear_reqs();
        put_br(0, 0, 9, 32'hE000); put_br(1, 0, 9, 32'hE100);
        put_mv(0, 3, 4, 32'hE200); put_mv(1, 3, 4, 32'hE300);
        step("R4 port ties");

        // R8: a younger violation wins in the cycle after an older branch.
        clear_reqs();
        put_br(0, 1, 5, 32'hF000);
        step("R8 first");
        clear_reqs();
        put_mv(0, 1, 9, 32'hF100);
        step("R8 younger next cycle");

        // R7: one thread busy, others stay idle.
        clear_reqs();
        put_br(0, 2, 1, 32'h1234); put_mv(1, 2, 2, 32'h5678);
        step("R7 isolation");

        // Random mix with small sequence numbers so ties are frequent.
        for (int n = 0; n < 4000; n++) begin
            clear_reqs();
            for (int i = 0; i < NB; i++)
                if ($urandom % 2) put_br(i, int'($urandom % NT), int'($urandom % 8), int'($urandom));
            for (int j = 0; j < NM; j++)
                if ($urandom % 2) put_mv(j, int'($urandom % NT), int'($urandom % 8), int'($urandom));
            step("R2 R3 R4 R5 R6 R7 random");
        end

        clear_reqs();
        step("R1 final idle");
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: act running exp finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule